// File: doc/BRIEF.md
# MDIO Management Master with Bus Multiplexer

This block is a register-programmed management-bus master. Software writes a parameter word, a register address and a command. The block then runs one management transaction, either a clause-22 frame or a clause-45 address-plus-data pair of frames. The transaction goes out on one bus chosen from a set of internal and external MDIO buses. A level done flag reports completion. On a read, the 16 data bits returned by the PHY are held for software in a read-data register.

Each bus has its own MDC output, MDIO output value, MDIO output enable and MDIO input. Only the bus chosen for the running transaction toggles its clock or drives its data line. Separate rate words for internal and external buses set the MDC period in core-clock cycles. An ownership bit must be set before the block may start a transaction on an external bus, which could otherwise be driven by another master.

Top module: `mdio_mux_master`

## Requirements
- R1: After reset, every MDC output is low, every MDIO output enable is low, the status word (word 7) reads 0 and the read-data word (word 4) reads 0.
- R2: Register words, by 3-bit word address: 0 internal rate, 1 external rate, 2 ownership (bit 28), 3 parameter, 4 read data, 5 register address, 6 command, 7 status. Parameter fields: write data [15:0], PHY address [20:16], clause-45 flag [21], bus number [24:22], internal flag [25]. Command 1 with clause-45 flag clear sends, MSB first, 32 ones, start 01, opcode 01, PHY address, register address bits [4:0] from word 5, turnaround 10 and the 16 write-data bits, with the output enable high for all 64 bits.
- R3: Command 2 with clause-45 flag clear sends the same frame with opcode 10. The enable falls for the last 18 bits (turnaround and data). The 16 bits sampled on the last 16 MDC rising edges appear in read-data bits [15:0], with bits [31:16] reading zero.
- R4: With the clause-45 flag set, the block sends an address frame first: start 00, opcode 00, PHY address, device address from word 5 bits [20:16], turnaround 10, then word 5 bits [15:0]. A second frame follows with start 00 and opcode 01 (write) or 11 (read), and it carries data as in R2/R3. Done stays 0 until the second frame ends.
- R5: Status bit 0 (done) rises when the transaction ends and holds until command 0 is written. Command 0 written during a transaction stops it at once: MDC returns low and the data line is released.
- R6: The internal flag set selects bus index equal to the bus number. With the flag clear, the index is 8 plus the bus number. Only the selected bus toggles MDC and enables MDIO; all others hold MDC low with the enable low.
- R7: A rate word holds a divisor in [15:0] and a dividend in [31:16]. The MDC period P is divisor*(dividend+1) core cycles, with a minimum of 2. MDC is high for P-floor(P/2) cycles of each period. Internal buses use word 0 and external buses use word 1.
- R8: The MDIO output value and enable change only when MDC falls. They stay constant while MDC is high, so the PHY samples a stable bit on each rising edge.
- R9: A command of 1 or 2 written while a transaction is running is ignored, and the running frame continues unchanged.
- R10: A command that targets an external bus is ignored while ownership bit 28 is clear. No MDC edge appears on any bus and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid one cycle later |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (registered) |
| mdc_o | output | 16 | MDC per bus, internal buses 0..7 then external 8..15 |
| mdio_o | output | 16 | MDIO output value per bus |
| mdio_oe | output | 16 | MDIO output enable per bus; low means released |
| mdio_i | input | 16 | MDIO input per bus |

## Verification
Errors in the shift register or slot counter show at the ports within one frame as wrong bits or wrong enable timing on the selected bus, because every bit is captured at each MDC rise. A stale bus index shows immediately as clock edges on a bus that should stay quiet. A wrong rate split shows in the MDC period and high time measured over the first two rising edges. A mishandled done or cancel state shows on the next status read, or as MDC edges that continue after command 0. A second clause-45 frame that is skipped or started too early changes the rise count from 128 and the done read taken between the two frames.

// File: rtl/mdio_mux_pkg.sv
// Package: shared field positions, register word map and frame builders
// for the MDIO management master. Assumes 16 buses at most (3-bit bus field).
package mdio_mux_pkg;

    localparam int DATA_W    = 32;
    localparam int REG_AW    = 3;
    localparam int PRM_W     = 26;   // stored parameter bits
    localparam int RADDR_W   = 21;   // stored register-address bits
    localparam int FRAME_W   = 64;   // bits per management frame
    localparam int SLOT_W    = $clog2(FRAME_W);
    localparam int RELEASE_N = 18;   // turnaround + data bits released on a read

    // parameter word fields
    localparam int FLD_PHY_LO = 16;
    localparam int FLD_C45    = 21;
    localparam int FLD_BUS_LO = 22;
    localparam int FLD_INT    = 25;
    localparam int OWN_BIT    = 28;

    // register word map
    localparam logic [REG_AW-1:0] A_RATE_INT = 3'd0;
    localparam logic [REG_AW-1:0] A_RATE_EXT = 3'd1;
    localparam logic [REG_AW-1:0] A_OWN      = 3'd2;
    localparam logic [REG_AW-1:0] A_PARAM    = 3'd3;
    localparam logic [REG_AW-1:0] A_RDATA    = 3'd4;
    localparam logic [REG_AW-1:0] A_RADDR    = 3'd5;
    localparam logic [REG_AW-1:0] A_CMD      = 3'd6;
    localparam logic [REG_AW-1:0] A_STAT     = 3'd7;

    typedef enum logic [1:0] {
        CMD_STOP  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } cmd_e;

    localparam logic [1:0] TA_DRIVE = 2'b10;

    // Assemble a frame, MSB first on the wire.
    function automatic logic [FRAME_W-1:0] frame_word(
        input logic [1:0]  st,
        input logic [1:0]  op,
        input logic [4:0]  phy,
        input logic [4:0]  sub,
        input logic [15:0] dat);
        return {32'hFFFF_FFFF, st, op, phy, sub, TA_DRIVE, dat};
    endfunction

    // Output-enable pattern: reads release turnaround and data bits.
    function automatic logic [FRAME_W-1:0] drive_mask(input logic rel);
        return rel ? {{(FRAME_W-RELEASE_N){1'b1}}, {RELEASE_N{1'b0}}}
                   : {FRAME_W{1'b1}};
    endfunction

endpackage

// File: rtl/mdio_regfile.sv
// Module: register file and command decode.
// Holds rate, ownership, parameter and address words; turns command writes
// into start / cancel pulses. Assumes single-cycle write strobes.
module mdio_regfile
    import mdio_mux_pkg::*;
#(
    parameter logic [DATA_W-1:0] RATE_RST = 32'h0001_0002
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [REG_AW-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               busy_i,
    input  logic               done_i,
    input  logic [15:0]        rd_result_i,
    output logic [DATA_W-1:0]  rate_int_o,
    output logic [DATA_W-1:0]  rate_ext_o,
    output logic [PRM_W-1:0]   param_o,
    output logic [RADDR_W-1:0] raddr_o,
    output logic               start_o,
    output logic               start_rd_o,
    output logic               cancel_o
);

    logic              own_q;
    logic [DATA_W-1:0] rd_mux;
    logic              cmd_wr;
    logic              cmd_go;

    // Purpose: decode a command write into start or cancel.
    always_comb begin
        cmd_wr     = wr_en && (addr == A_CMD);
        cmd_go     = (wdata == DATA_W'(CMD_WRITE)) || (wdata == DATA_W'(CMD_READ));
        start_o    = cmd_wr && cmd_go && !busy_i && (param_o[FLD_INT] || own_q);
        start_rd_o = wdata[1];
        cancel_o   = cmd_wr && (wdata == DATA_W'(CMD_STOP));
    end

    // Purpose: read multiplexer.
    always_comb begin
        case (addr)
            A_RATE_INT: rd_mux = rate_int_o;
            A_RATE_EXT: rd_mux = rate_ext_o;
            A_OWN:      rd_mux = DATA_W'(own_q) << OWN_BIT;
            A_PARAM:    rd_mux = DATA_W'(param_o);
            A_RDATA:    rd_mux = {16'b0, rd_result_i};
            A_RADDR:    rd_mux = DATA_W'(raddr_o);
            A_STAT:     rd_mux = DATA_W'(done_i);
            default:    rd_mux = '0;
        endcase
    end

    // Purpose: register writes and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_int_o <= RATE_RST;
            rate_ext_o <= RATE_RST;
            own_q      <= 1'b0;
            param_o    <= '0;
            raddr_o    <= '0;
            rdata      <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_RATE_INT: rate_int_o <= wdata;
                    A_RATE_EXT: rate_ext_o <= wdata;
                    A_OWN:      own_q      <= wdata[OWN_BIT];
                    A_PARAM:    param_o    <= wdata[PRM_W-1:0];
                    A_RADDR:    raddr_o    <= wdata[RADDR_W-1:0];
                    default:    ;
                endcase
            end
            if (rd_en) rdata <= rd_mux;
        end
    end

    assert_blocked_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !param_o[FLD_INT]) |-> own_q);

endmodule

// File: rtl/mdio_clkgen.sv
// Module: MDC generator. While run_i is high it produces MDC with period
// divisor*(dividend+1) core cycles (minimum 2), low for floor(P/2).
// rise_o / fall_o mark the cycle whose clock edge changes MDC.
module mdio_clkgen
    import mdio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DATA_W-1:0] rate_i,
    output logic              mdc_o,
    output logic              rise_o,
    output logic              fall_o
);

    localparam int PW = DATA_W + 1;

    logic [PW-1:0] per_raw;
    logic [PW-1:0] per_eff;
    logic [PW-1:0] low_len;
    logic [PW-1:0] high_len;
    logic [PW-1:0] cnt_q;

    // Purpose: phase lengths from the selected rate word.
    always_comb begin
        per_raw  = PW'(rate_i[15:0]) * (PW'(rate_i[31:16]) + PW'(1));
        per_eff  = (per_raw < PW'(2)) ? PW'(2) : per_raw;
        low_len  = per_eff >> 1;
        high_len = per_eff - low_len;
        rise_o   = run_i && !mdc_o && (cnt_q >= low_len - PW'(1));
        fall_o   = run_i &&  mdc_o && (cnt_q >= high_len - PW'(1));
    end

    // Purpose: phase counter and MDC level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else if (rise_o) begin
            cnt_q <= '0;
            mdc_o <= 1'b1;
        end else if (fall_o) begin
            cnt_q <= '0;
            mdc_o <= 1'b0;
        end else begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);

endmodule

// File: rtl/mdio_frame_engine.sv
// Module: frame shifter. Latches the transaction at start, shifts one bit
// per MDC period (changing on the falling edge), samples read data on the
// rising edge and chains the second clause-45 frame. Assumes mdio_in_i is
// already synchronous to clk.
module mdio_frame_engine
    import mdio_mux_pkg::*;
#(
    parameter int NB   = 8,
    parameter int IDXW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               rd_i,
    input  logic               cancel_i,
    input  logic [PRM_W-1:0]   param_i,
    input  logic [RADDR_W-1:0] raddr_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               mdc_i,
    input  logic               mdio_in_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [15:0]        rdval_o,
    output logic               mdio_o,
    output logic               mdio_oe_o,
    output logic [IDXW-1:0]    bus_idx_o,
    output logic               ext_o
);

    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] oe_q;
    logic [SLOT_W-1:0]  slot_q;
    logic               second_q;
    logic               c45_q;
    logic               rd_q;
    logic [4:0]         phy_q;
    logic [4:0]         dev_q;
    logic [15:0]        wdat_q;
    logic [FRAME_W-1:0] first_frame;
    logic [FRAME_W-1:0] first_oe;
    logic [FRAME_W-1:0] next_frame;
    logic [2:0]         busnum;

    // Purpose: build the first frame and the chained clause-45 data frame.
    always_comb begin
        busnum = param_i[FLD_BUS_LO +: 3];
        if (param_i[FLD_C45]) begin
            first_frame = frame_word(2'b00, 2'b00, param_i[FLD_PHY_LO +: 5],
                                     raddr_i[20:16], raddr_i[15:0]);
            first_oe    = drive_mask(1'b0);
        end else begin
            first_frame = frame_word(2'b01, rd_i ? 2'b10 : 2'b01,
                                     param_i[FLD_PHY_LO +: 5], raddr_i[4:0],
                                     rd_i ? 16'h0 : param_i[15:0]);
            first_oe    = drive_mask(rd_i);
        end
        next_frame = frame_word(2'b00, rd_q ? 2'b11 : 2'b01, phy_q, dev_q,
                                rd_q ? 16'h0 : wdat_q);
        mdio_o    = busy_o && frame_q[FRAME_W-1];
        mdio_oe_o = busy_o && oe_q[FRAME_W-1];
    end

    // Purpose: transaction sequencing, bit shifting and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o    <= 1'b0;
            done_o    <= 1'b0;
            rdval_o   <= '0;
            frame_q   <= '0;
            oe_q      <= '0;
            slot_q    <= '0;
            second_q  <= 1'b0;
            c45_q     <= 1'b0;
            rd_q      <= 1'b0;
            phy_q     <= '0;
            dev_q     <= '0;
            wdat_q    <= '0;
            bus_idx_o <= '0;
            ext_o     <= 1'b0;
        end else if (cancel_i) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
        end else if (start_i) begin
            busy_o    <= 1'b1;
            done_o    <= 1'b0;
            rdval_o   <= '0;
            frame_q   <= first_frame;
            oe_q      <= first_oe;
            slot_q    <= '0;
            second_q  <= 1'b0;
            c45_q     <= param_i[FLD_C45];
            rd_q      <= rd_i;
            phy_q     <= param_i[FLD_PHY_LO +: 5];
            dev_q     <= raddr_i[20:16];
            wdat_q    <= param_i[15:0];
            ext_o     <= !param_i[FLD_INT];
            bus_idx_o <= param_i[FLD_INT] ? IDXW'(busnum) : IDXW'(NB) + IDXW'(busnum);
        end else if (busy_o) begin
            if (rise_i && !oe_q[FRAME_W-1])
                rdval_o <= {rdval_o[14:0], mdio_in_i};
            if (fall_i) begin
                if (slot_q == SLOT_W'(FRAME_W - 1)) begin
                    slot_q <= '0;
                    if (c45_q && !second_q) begin
                        second_q <= 1'b1;
                        frame_q  <= next_frame;
                        oe_q     <= drive_mask(rd_q);
                    end else begin
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                    end
                end else begin
                    slot_q  <= slot_q + SLOT_W'(1);
                    frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                    oe_q    <= {oe_q[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!$past(c45_q) || $past(second_q)));

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cancel_i && !start_i) |=> done_o);

    assert_drive_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mdc_i && !fall_i && !cancel_i) |=> ($stable(mdio_o) && $stable(mdio_oe_o)));

endmodule

// File: rtl/mdio_bus_steer.sv
// Module: per-bus steering. Routes MDC and MDIO drive to the selected bus
// only and returns that bus's MDIO input. Unselected buses stay quiet.
module mdio_bus_steer #(
    parameter int NB   = 8,
    parameter int IDXW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic [IDXW-1:0]   idx_i,
    input  logic              mdc_i,
    input  logic              mdio_i,
    input  logic              mdio_oe_i,
    output logic [2*NB-1:0]   mdc_v,
    output logic [2*NB-1:0]   mdio_v,
    output logic [2*NB-1:0]   mdio_oe_v,
    input  logic [2*NB-1:0]   mdio_in_v,
    output logic              mdio_in_o
);

    localparam int NBUS = 2 * NB;

    // Purpose: one gated lane per bus.
    for (genvar g = 0; g < NBUS; g++) begin : g_lane
        logic hit;
        assign hit          = active_i && (idx_i == IDXW'(g));
        assign mdc_v[g]     = hit && mdc_i;
        assign mdio_v[g]    = hit && mdio_i;
        assign mdio_oe_v[g] = hit && mdio_oe_i;
    end

    assign mdio_in_o = mdio_in_v[idx_i];

    assert_one_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdc_v));

    assert_one_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mdio_oe_v));

endmodule

// File: rtl/mdio_mux_master.sv
// Module: top of the MDIO management master with bus multiplexer.
// Connects register file, MDC generator, frame engine and bus steering.
// Assumes NB_SIDE <= 8 because the bus field is 3 bits wide.
module mdio_mux_master
    import mdio_mux_pkg::*;
#(
    parameter int                NB_SIDE  = 8,
    parameter logic [DATA_W-1:0] RATE_RST = 32'h0001_0002,
    localparam int               NBUS     = 2 * NB_SIDE,
    localparam int               IDXW     = $clog2(NBUS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NBUS-1:0]   mdc_o,
    output logic [NBUS-1:0]   mdio_o,
    output logic [NBUS-1:0]   mdio_oe,
    input  logic [NBUS-1:0]   mdio_i
);

    logic [DATA_W-1:0]  rate_int, rate_ext, rate_sel;
    logic [PRM_W-1:0]   param;
    logic [RADDR_W-1:0] raddr;
    logic               start, start_rd, cancel;
    logic               busy, done, ext_sel;
    logic [15:0]        rdval;
    logic               mdc, rise, fall;
    logic               bit_o, bit_oe, bit_in;
    logic [IDXW-1:0]    bus_idx;

    assign rate_sel = ext_sel ? rate_ext : rate_int;

    mdio_regfile #(.RATE_RST(RATE_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .busy_i(busy), .done_i(done), .rd_result_i(rdval),
        .rate_int_o(rate_int), .rate_ext_o(rate_ext), .param_o(param),
        .raddr_o(raddr), .start_o(start), .start_rd_o(start_rd),
        .cancel_o(cancel)
    );

    mdio_clkgen u_clk (
        .clk(clk), .rst_n(rst_n), .run_i(busy), .rate_i(rate_sel),
        .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
    );

    mdio_frame_engine #(.NB(NB_SIDE), .IDXW(IDXW)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_i(start_rd),
        .cancel_i(cancel), .param_i(param), .raddr_i(raddr),
        .rise_i(rise), .fall_i(fall), .mdc_i(mdc), .mdio_in_i(bit_in),
        .busy_o(busy), .done_o(done), .rdval_o(rdval),
        .mdio_o(bit_o), .mdio_oe_o(bit_oe), .bus_idx_o(bus_idx),
        .ext_o(ext_sel)
    );

    mdio_bus_steer #(.NB(NB_SIDE), .IDXW(IDXW)) u_steer (
        .clk(clk), .rst_n(rst_n), .active_i(busy), .idx_i(bus_idx),
        .mdc_i(mdc), .mdio_i(bit_o), .mdio_oe_i(bit_oe),
        .mdc_v(mdc_o), .mdio_v(mdio_o), .mdio_oe_v(mdio_oe),
        .mdio_in_v(mdio_i), .mdio_in_o(bit_in)
    );

endmodule

// File: tb/tb_mdio_mux_master.sv
`timescale 1ns/1ps
module tb_mdio_mux_master;

    localparam int NBUS = 16;
    localparam logic [2:0] W_RI = 3'd0, W_RE = 3'd1, W_OWN = 3'd2, W_PRM = 3'd3,
                           W_RD = 3'd4, W_ADR = 3'd5, W_CMD = 3'd6, W_ST = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NBUS-1:0] mdc_o, mdio_o, mdio_oe, mdio_i;

    always #2.5 clk = ~clk;

    mdio_mux_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int vec = 0, bad = 0, cyc = 0;
    int mon_bus = 0;
    int rises [NBUS];
    int hi_cyc = 0, mism = 0, t_r1 = 0, t_r2 = 0;
    logic [127:0] cap = '0, capoe = '0;
    logic [NBUS-1:0] mdc_prev = '0;
    logic held_o = 1'b0, held_oe = 1'b0;
    logic resp_en = 1'b0;
    logic [15:0] resp_data = '0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    // bus monitor, sampled on the falling core-clock edge
    always @(negedge clk) begin
        cyc++;
        for (int i = 0; i < NBUS; i++) begin
            if (mdc_o[i] && !mdc_prev[i]) begin
                if (i == mon_bus) begin
                    if (rises[i] < 128) begin
                        cap[127 - rises[i]]   = mdio_oe[i] ? mdio_o[i] : 1'b1;
                        capoe[127 - rises[i]] = mdio_oe[i];
                    end
                    if (rises[i] == 0) t_r1 = cyc;
                    if (rises[i] == 1) t_r2 = cyc;
                    held_o  = mdio_o[i];
                    held_oe = mdio_oe[i];
                end
                rises[i]++;
            end else if (mdc_o[i] && i == mon_bus) begin
                if (mdio_o[i] !== held_o || mdio_oe[i] !== held_oe) mism++;
            end
            if (mdc_o[i] && i == mon_bus) hi_cyc++;
        end
        mdc_prev = mdc_o;
        if (cyc == 150000) begin
            bad++;
            $display("FAIL watchdog R5 actual=timeout expected=completion");
            summary();
        end
    end

    // PHY responder: drives read data for slots 48..63 of each frame
    always_comb begin
        int slot;
        mdio_i = '1;
        slot = rises[mon_bus] % 64;
        if (resp_en && slot >= 48) mdio_i[mon_bus] = resp_data[63 - slot];
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [63:0] exf(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] sub,
                                        input logic [15:0] dat);
        return {32'hFFFF_FFFF, st, op, phy, sub, 2'b10, dat};
    endfunction

    function automatic logic [31:0] prm(input bit intl, input int bus, input bit c45,
                                        input int phy, input logic [15:0] dat);
        return (32'(intl) << 25) | (32'(bus) << 22) | (32'(c45) << 21) | (32'(phy) << 16) | 32'(dat);
    endfunction

    function automatic int others_rises();
        int s = 0;
        for (int i = 0; i < NBUS; i++) if (i != mon_bus) s += rises[i];
        return s;
    endfunction

    task automatic clear_mon();
        for (int i = 0; i < NBUS; i++) rises[i] = 0;
        cap = '0; capoe = '0; hi_cyc = 0; mism = 0; t_r1 = 0; t_r2 = 0;
    endtask

    task automatic go(input logic [31:0] p, input logic [31:0] a, input logic [31:0] c);
        wr(W_CMD, 32'd0);
        clear_mon();
        wr(W_PRM, p);
        wr(W_ADR, a);
        wr(W_CMD, c);
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int k = 0; k < 3000; k++) begin
            rd(W_ST, s);
            if (s[0]) begin ok = 1; break; end
        end
    endtask

    task automatic wait_rises(input int n);
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (rises[mon_bus] >= n) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(mdc_o == '0, "R1 mdc after reset", 64'(mdc_o), 64'h0);
        chk(mdio_oe == '0, "R1 oe after reset", 64'(mdio_oe), 64'h0);
        rd(W_ST, d);   chk(d == 32'h0, "R1 status after reset", 64'(d), 64'h0);
        rd(W_RD, d);   chk(d == 32'h0, "R1 read data after reset", 64'(d), 64'h0);
    endtask

    task automatic t_c22_write();
        bit ok;
        logic [63:0] e;
        mon_bus = 5;
        go(prm(1, 5, 0, 3, 16'hA5C3), 32'h12, 32'd1);
        wait_done(ok);
        chk(ok, "R5 done after c22 write", 64'(ok), 64'h1);
        e = exf(2'b01, 2'b01, 5'd3, 5'h12, 16'hA5C3);
        chk(cap[127:64] == e, "R2 c22 write frame", cap[127:64], e);
        chk(capoe[127:64] == '1, "R2 enable through write", capoe[127:64], '1);
        chk(others_rises() == 0, "R6 other buses quiet", 64'(others_rises()), 64'h0);
        chk(hi_cyc == 128, "R7 internal high time", 64'(hi_cyc), 64'd128);
        chk(t_r2 - t_r1 == 4, "R7 internal period", 64'(t_r2 - t_r1), 64'd4);
        chk(mism == 0, "R8 stable while MDC high", 64'(mism), 64'h0);
    endtask

    task automatic t_c22_read();
        bit ok;
        logic [31:0] d;
        logic [63:0] e;
        mon_bus = 2; resp_en = 1; resp_data = 16'hBEEF;
        go(prm(1, 2, 0, 7, 16'h0), 32'h05, 32'd2);
        wait_done(ok);
        e = exf(2'b01, 2'b10, 5'd7, 5'h05, 16'h0);
        chk(ok, "R3 done after c22 read", 64'(ok), 64'h1);
        chk(cap[127:82] == e[63:18], "R3 c22 read header", 64'(cap[127:82]), 64'(e[63:18]));
        chk(capoe[81:64] == '0, "R3 line released", 64'(capoe[81:64]), 64'h0);
        chk(capoe[127:82] == '1, "R3 header driven", 64'(capoe[127:82]), 64'h3FFF_FFFF_FFFF);
        rd(W_RD, d);
        chk(d == 32'h0000_BEEF, "R3 read data", 64'(d), 64'h0000_BEEF);
        resp_en = 0;
    endtask

    task automatic t_c45_read();
        bit ok;
        logic [31:0] d;
        logic [63:0] ea, eb;
        mon_bus = 1; resp_en = 1; resp_data = 16'h5A5A;
        go(prm(1, 1, 1, 17, 16'h0), (32'd3 << 16) | 32'h1234, 32'd2);
        wait_rises(70);
        rd(W_ST, d);
        chk(d[0] == 1'b0, "R4 no done between frames", 64'(d[0]), 64'h0);
        wait_done(ok);
        ea = exf(2'b00, 2'b00, 5'd17, 5'd3, 16'h1234);
        eb = exf(2'b00, 2'b11, 5'd17, 5'd3, 16'h0);
        chk(cap[127:64] == ea, "R4 address frame", cap[127:64], ea);
        chk(cap[63:18] == eb[63:18], "R4 read frame header", 64'(cap[63:18]), 64'(eb[63:18]));
        chk(rises[1] == 128, "R4 two frames", 64'(rises[1]), 64'd128);
        rd(W_RD, d);
        chk(d == 32'h0000_5A5A, "R4 c45 read data", 64'(d), 64'h5A5A);
        resp_en = 0;
    endtask

    task automatic t_ext_blocked();
        logic [31:0] d;
        int tot;
        wr(W_OWN, 32'h0);
        mon_bus = 11;
        go(prm(0, 3, 0, 9, 16'h1234), 32'h04, 32'd1);
        repeat (200) @(negedge clk);
        tot = others_rises() + rises[11];
        chk(tot == 0, "R10 no edges without ownership", 64'(tot), 64'h0);
        rd(W_ST, d);
        chk(d[0] == 1'b0, "R10 no done without ownership", 64'(d[0]), 64'h0);
    endtask

    task automatic t_ext_owned();
        bit ok;
        logic [63:0] e;
        wr(W_OWN, 32'h1000_0000);
        mon_bus = 11;
        go(prm(0, 3, 0, 9, 16'h1234), 32'h04, 32'd1);
        wait_done(ok);
        e = exf(2'b01, 2'b01, 5'd9, 5'h04, 16'h1234);
        chk(cap[127:64] == e, "R10 external write frame", cap[127:64], e);
        chk(others_rises() == 0, "R6 external index 8+bus", 64'(others_rises()), 64'h0);
        chk(hi_cyc == 192, "R7 external high time", 64'(hi_cyc), 64'd192);
        chk(t_r2 - t_r1 == 5, "R7 external period", 64'(t_r2 - t_r1), 64'd5);
    endtask

    task automatic t_busy_ignore();
        bit ok;
        logic [63:0] e;
        mon_bus = 5;
        go(prm(1, 5, 0, 3, 16'h1111), 32'h06, 32'd1);
        wait_rises(5);
        wr(W_CMD, 32'd2);
        wait_done(ok);
        e = exf(2'b01, 2'b01, 5'd3, 5'h06, 16'h1111);
        chk(rises[5] == 64, "R9 single frame", 64'(rises[5]), 64'd64);
        chk(cap[127:64] == e, "R9 frame unchanged", cap[127:64], e);
        chk(mism == 0, "R8 stable while MDC high", 64'(mism), 64'h0);
    endtask

    task automatic t_done_cancel();
        logic [31:0] d;
        int r_at;
        repeat (100) @(negedge clk);
        rd(W_ST, d);  chk(d[0] == 1'b1, "R5 done holds", 64'(d[0]), 64'h1);
        wr(W_CMD, 32'd0);
        rd(W_ST, d);  chk(d[0] == 1'b0, "R5 done cleared", 64'(d[0]), 64'h0);
        mon_bus = 5;
        go(prm(1, 5, 0, 3, 16'h0), 32'h01, 32'd2);
        wait_rises(10);
        wr(W_CMD, 32'd0);
        repeat (3) @(negedge clk);
        r_at = rises[5];
        chk(mdc_o == '0 && mdio_oe == '0, "R5 cancel idles bus", 64'({mdc_o, mdio_oe}), 64'h0);
        repeat (300) @(negedge clk);
        chk(rises[5] == r_at, "R5 no edges after cancel", 64'(rises[5]), 64'(r_at));
        rd(W_ST, d);  chk(d[0] == 1'b0, "R5 no done after cancel", 64'(d[0]), 64'h0);
    endtask

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(W_RI, 32'h0001_0002);
        wr(W_RE, 32'h0000_0005);
        t_c22_write();
        t_c22_read();
        t_c45_read();
        t_ext_blocked();
        t_ext_owned();
        t_busy_ignore();
        t_done_cancel();
        summary();
    end

endmodule